// File: doc/BRIEF.md
# Block Storage Controller Register File

This block holds the control registers that software programs to set up a transfer on a small block-storage controller. It sits on a simple memory-mapped request/response bus. Software selects a disk, a starting block, a transfer length in blocks, a physical memory address for the data, and finally writes a command word. The command write launches an external transfer engine through a one-cycle strobe. The data movement itself happens outside this block.

Each write is checked against the geometry of the selected disk. The per-disk block counts come from a parameter table. A disk number outside the table or a block number past the end of the disk is refused and reported through a status register. A transfer length that is too large is not refused; it is trimmed to fit. Register 2 reads back the capacity of the selected disk in bytes. An access to an index with no register behind it gets a bus error response instead of stopping the system.

Top module: `stor_ctl_regs`

## Requirements
- R1: After reset the selected disk, block, transfer count, address and command are all zero, the status is OK (code 0), and neither `rsp_valid` nor `xfer_start` is high.
- R2: The register index is `req_addr[ADDR_W-1:3]` and address bits 2:0 are ignored. Indices 0 to 5 are disk, block, capacity/count, address, command and status, in that order.
- R3: Every request cycle produces `rsp_valid` high in the following cycle and no other cycle does. Write responses carry `rsp_rdata` = 0.
- R4: A write to index 0 with a value below NUM_DISKS selects that disk and sets status to OK (0). Any other value leaves the disk unchanged and sets status to bad-disk (1).
- R5: A write to index 1 with a value below the selected disk's block count sets the block and leaves status unchanged. Otherwise the block is unchanged and status becomes bad-block (2).
- R6: A write to index 2 sets the transfer count to the value, or to block count − 1 if the value is at or above the block count. Status becomes OK. The count appears on `xfer_count`.
- R7: A write to index 3 latches the full word as the physical address on `xfer_addr` and sets status to OK.
- R8: A write to index 4 latches the command on `xfer_cmd` and raises `xfer_start` for exactly the following cycle. Status is unchanged.
- R9: A read of index 2 returns the selected disk's block count multiplied by BLOCK_BYTES. Reads of indices 0, 1, 3, 4 and 5 return the disk, block, address, command and status zero-extended.
- R10: A read or write of index 6 or higher gets `rsp_err` = 1 with `rsp_rdata` = 0 and changes no state. A write to index 5 is ignored and gets no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the register |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_rdata | output | DATA_W | Read data, zero on writes and errors |
| rsp_err | output | 1 | Access to an unmapped index |
| xfer_start | output | 1 | One-cycle launch strobe after a command write |
| xfer_cmd | output | DATA_W | Latched command word |
| xfer_disk | output | DISK_W | Selected disk |
| xfer_block | output | BLK_W | Starting block |
| xfer_count | output | BLK_W | Transfer count after trimming |
| xfer_addr | output | DATA_W | Physical memory address |

## Verification
The hardest case to reach is a valid block write that follows a refused one. Here the status must keep its bad-block code and not fall back to OK. Reaching it needs a particular order of writes, with each disk selected in turn. For every disk the bench sweeps every 8-bit block value in ascending order, which passes the boundary from accepted to refused. It then writes a legal block again. The bench also sweeps every transfer count and every byte address, with the expected results worked out arithmetically from the disk table.

// File: rtl/stor_ctl_pkg.sv
package stor_ctl_pkg;

   typedef enum logic [1:0] {
      ST_OK        = 2'd0,
      ST_BAD_DISK  = 2'd1,
      ST_BAD_BLOCK = 2'd2
   } status_e;

   localparam int RG_DISK   = 0;
   localparam int RG_BLOCK  = 1;
   localparam int RG_COUNT  = 2;
   localparam int RG_ADDR   = 3;
   localparam int RG_CMD    = 4;
   localparam int RG_STATUS = 5;
   localparam int NUM_REGS  = 6;
   localparam int REG_STRIDE_BITS = 3;

endpackage

// File: rtl/stor_ctl_decode.sv
module stor_ctl_decode
   import stor_ctl_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_REGS-1:0] sel,
   output logic                unmapped
);
   localparam int IDX_W = ADDR_W - REG_STRIDE_BITS;

   initial begin
      assert (IDX_W >= $clog2(NUM_REGS))
         else $error("stor_ctl_decode: ADDR_W too small for the register set");
   end

   logic [IDX_W-1:0] idx;
   assign idx = addr[ADDR_W-1:REG_STRIDE_BITS];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
      assign sel[g] = (idx == IDX_W'(g));
   end

   assign unmapped = ~|sel;
endmodule

// File: rtl/stor_ctl_geom.sv
module stor_ctl_geom #(
   parameter int NUM_DISKS = 3,
   parameter int DISK_W    = 2,
   parameter int BLK_W     = 8,
   parameter int DATA_W    = 32,
   parameter int BLK_SHIFT = 9,
   parameter logic [NUM_DISKS*BLK_W-1:0] DISK_BLOCKS = '1
) (
   input  logic [DISK_W-1:0] disk,
   output logic [BLK_W-1:0]  blocks,
   output logic [DATA_W-1:0] size_bytes
);
   initial begin
      assert (BLK_W + BLK_SHIFT <= DATA_W)
         else $error("stor_ctl_geom: capacity does not fit in DATA_W");
   end

   logic [BLK_W-1:0] tab [NUM_DISKS];

   for (genvar g = 0; g < NUM_DISKS; g++) begin : g_tab
      assign tab[g] = DISK_BLOCKS[g*BLK_W +: BLK_W];
      initial begin
         assert (DISK_BLOCKS[g*BLK_W +: BLK_W] != '0)
            else $error("stor_ctl_geom: disk %0d has no blocks", g);
      end
   end

   always_comb begin
      blocks = tab[0];
      for (int i = 1; i < NUM_DISKS; i++) begin
         if (disk == DISK_W'(i)) blocks = tab[i];
      end
   end

   assign size_bytes = DATA_W'(blocks) << BLK_SHIFT;
endmodule

// File: rtl/stor_ctl_check.sv
module stor_ctl_check #(
   parameter int DATA_W    = 32,
   parameter int BLK_W     = 8,
   parameter int NUM_DISKS = 3
) (
   input  logic [DATA_W-1:0] wdata,
   input  logic [BLK_W-1:0]  blocks,
   output logic              disk_ok,
   output logic              blk_ok,
   output logic [BLK_W-1:0]  cnt_val
);
   localparam logic [DATA_W-1:0] DISK_LIM = DATA_W'(NUM_DISKS);

   initial begin
      assert (BLK_W <= DATA_W)
         else $error("stor_ctl_check: BLK_W wider than DATA_W");
   end

   logic [DATA_W-1:0] blocks_ext;
   assign blocks_ext = DATA_W'(blocks);

   assign disk_ok = (wdata < DISK_LIM);
   assign blk_ok  = (wdata < blocks_ext);
   assign cnt_val = blk_ok ? wdata[BLK_W-1:0] : (blocks - BLK_W'(1));
endmodule

// File: rtl/stor_ctl_regs.sv
module stor_ctl_regs
   import stor_ctl_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 6,
   parameter int NUM_DISKS   = 3,
   parameter int BLK_W       = 8,
   parameter int BLOCK_BYTES = 512,
   parameter logic [NUM_DISKS*BLK_W-1:0] DISK_BLOCKS = {8'd200, 8'd5, 8'd16},
   localparam int DISK_W    = (NUM_DISKS > 1) ? $clog2(NUM_DISKS) : 1,
   localparam int BLK_SHIFT = $clog2(BLOCK_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err,
   output logic              xfer_start,
   output logic [DATA_W-1:0] xfer_cmd,
   output logic [DISK_W-1:0] xfer_disk,
   output logic [BLK_W-1:0]  xfer_block,
   output logic [BLK_W-1:0]  xfer_count,
   output logic [DATA_W-1:0] xfer_addr
);
   initial begin
      assert ((1 << BLK_SHIFT) == BLOCK_BYTES)
         else $error("stor_ctl_regs: BLOCK_BYTES must be a power of two");
      assert (DISK_W <= DATA_W)
         else $error("stor_ctl_regs: too many disks for DATA_W");
   end

   logic [NUM_REGS-1:0] sel;
   logic                unmapped;
   logic [BLK_W-1:0]    cur_blocks;
   logic [DATA_W-1:0]   cur_size;
   logic                disk_ok, blk_ok;
   logic [BLK_W-1:0]    cnt_val;

   logic [DISK_W-1:0] cur_disk;
   logic [BLK_W-1:0]  cur_block;
   logic [BLK_W-1:0]  cur_count;
   logic [DATA_W-1:0] phys_addr;
   logic [DATA_W-1:0] cmd_q;
   status_e           status_q;
   logic              start_q;
   logic              rsp_valid_q, rsp_err_q;
   logic [DATA_W-1:0] rsp_rdata_q;
   logic [DATA_W-1:0] rd_mux;

   stor_ctl_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr     (req_addr),
      .sel      (sel),
      .unmapped (unmapped)
   );

   stor_ctl_geom #(
      .NUM_DISKS   (NUM_DISKS),
      .DISK_W      (DISK_W),
      .BLK_W       (BLK_W),
      .DATA_W      (DATA_W),
      .BLK_SHIFT   (BLK_SHIFT),
      .DISK_BLOCKS (DISK_BLOCKS)
   ) u_geom (
      .disk       (cur_disk),
      .blocks     (cur_blocks),
      .size_bytes (cur_size)
   );

   stor_ctl_check #(
      .DATA_W    (DATA_W),
      .BLK_W     (BLK_W),
      .NUM_DISKS (NUM_DISKS)
   ) u_check (
      .wdata   (req_wdata),
      .blocks  (cur_blocks),
      .disk_ok (disk_ok),
      .blk_ok  (blk_ok),
      .cnt_val (cnt_val)
   );

   logic wr_en, rd_en;
   assign wr_en = req_valid & req_write & ~unmapped;
   assign rd_en = req_valid & ~req_write & ~unmapped;

   always_comb begin
      rd_mux = '0;
      if (sel[RG_DISK])   rd_mux = DATA_W'(cur_disk);
      if (sel[RG_BLOCK])  rd_mux = DATA_W'(cur_block);
      if (sel[RG_COUNT])  rd_mux = cur_size;
      if (sel[RG_ADDR])   rd_mux = phys_addr;
      if (sel[RG_CMD])    rd_mux = cmd_q;
      if (sel[RG_STATUS]) rd_mux = DATA_W'(status_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_disk  <= '0;
         cur_block <= '0;
         cur_count <= '0;
         phys_addr <= '0;
         cmd_q     <= '0;
         status_q  <= ST_OK;
         start_q   <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (wr_en) begin
            if (sel[RG_DISK]) begin
               if (disk_ok) begin
                  cur_disk <= req_wdata[DISK_W-1:0];
                  status_q <= ST_OK;
               end else begin
                  status_q <= ST_BAD_DISK;
               end
            end
            if (sel[RG_BLOCK]) begin
               if (blk_ok) cur_block <= req_wdata[BLK_W-1:0];
               else        status_q  <= ST_BAD_BLOCK;
            end
            if (sel[RG_COUNT]) begin
               cur_count <= cnt_val;
               status_q  <= ST_OK;
            end
            if (sel[RG_ADDR]) begin
               phys_addr <= req_wdata;
               status_q  <= ST_OK;
            end
            if (sel[RG_CMD]) begin
               cmd_q   <= req_wdata;
               start_q <= 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_err_q   <= 1'b0;
         rsp_rdata_q <= '0;
      end else begin
         rsp_valid_q <= req_valid;
         rsp_err_q   <= req_valid & unmapped;
         rsp_rdata_q <= rd_en ? rd_mux : '0;
      end
   end

   assign rsp_valid  = rsp_valid_q;
   assign rsp_err    = rsp_err_q;
   assign rsp_rdata  = rsp_rdata_q;
   assign xfer_start = start_q;
   assign xfer_cmd   = cmd_q;
   assign xfer_disk  = cur_disk;
   assign xfer_block = cur_block;
   assign xfer_count = cur_count;
   assign xfer_addr  = phys_addr;

   // R3: one response per request, one cycle later
   p_rsp_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_rsp_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R4: refused disk number keeps the selection
   p_disk_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel[RG_DISK] && !disk_ok) |=>
         ($stable(cur_disk) && status_q == ST_BAD_DISK));
   p_disk_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel[RG_DISK] && disk_ok) |=>
         (status_q == ST_OK && cur_disk == $past(req_wdata[DISK_W-1:0])));

   // R5: refused block number keeps the block
   p_block_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel[RG_BLOCK] && !blk_ok) |=>
         ($stable(cur_block) && status_q == ST_BAD_BLOCK));

   // R6: trimmed count always fits the disk it was written for
   p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel[RG_COUNT]) |=> (xfer_count < $past(cur_blocks)));

   // R8: launch strobe tied to command writes
   p_start_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel[RG_CMD]) |=> xfer_start);
   p_start_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> $past(req_valid && req_write && sel[RG_CMD]));

   // R10: error responses carry no data
   p_err_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_valid && rsp_rdata == '0));
endmodule

// File: tb/stor_ctl_regs_tb.sv
module stor_ctl_regs_tb;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 6;
   localparam int NDISK  = 3;
   localparam int BLK_W  = 8;
   localparam int BBYTES = 512;
   localparam int DISK_W = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic              rsp_valid, rsp_err, xfer_start;
   logic [DATA_W-1:0] rsp_rdata, xfer_cmd, xfer_addr;
   logic [DISK_W-1:0] xfer_disk;
   logic [BLK_W-1:0]  xfer_block, xfer_count;

   int n_tests = 0;
   int n_fail  = 0;

   int m_disk = 0, m_block = 0, m_count = 0, m_status = 0;
   logic [DATA_W-1:0] m_addr = '0, m_cmd = '0;

   always #5 clk = ~clk;

   stor_ctl_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_DISKS(NDISK), .BLK_W(BLK_W),
      .BLOCK_BYTES(BBYTES), .DISK_BLOCKS({8'd200, 8'd5, 8'd16})
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .xfer_start(xfer_start),
      .xfer_cmd(xfer_cmd), .xfer_disk(xfer_disk), .xfer_block(xfer_block),
      .xfer_count(xfer_count), .xfer_addr(xfer_addr)
   );

   function automatic int blocks_of(int d);
      case (d)
         0: return 16;
         1: return 5;
         default: return 200;
      endcase
   endfunction

   task automatic check(bit ok, string tag, longint act, longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_outputs(string tag);
      check(xfer_disk == DISK_W'(m_disk), {tag, " disk"}, xfer_disk, m_disk);
      check(xfer_block == BLK_W'(m_block), {tag, " block"}, xfer_block, m_block);
      check(xfer_count == BLK_W'(m_count), {tag, " count"}, xfer_count, m_count);
      check(xfer_addr == m_addr, {tag, " addr"}, xfer_addr, m_addr);
      check(xfer_cmd == m_cmd, {tag, " cmd"}, xfer_cmd, m_cmd);
   endtask

   function automatic logic [DATA_W-1:0] exp_read(int idx);
      case (idx)
         0: return DATA_W'(m_disk);
         1: return DATA_W'(m_block);
         2: return DATA_W'(blocks_of(m_disk) * BBYTES);
         3: return m_addr;
         4: return m_cmd;
         5: return DATA_W'(m_status);
         default: return '0;
      endcase
   endfunction

   // model update per R4..R8, R10
   task automatic model_write(int idx, logic [DATA_W-1:0] v);
      case (idx)
         0: if (v < NDISK) begin m_disk = int'(v); m_status = 0; end
            else m_status = 1;
         1: if (v < DATA_W'(blocks_of(m_disk))) m_block = int'(v);
            else m_status = 2;
         2: begin
               if (v >= DATA_W'(blocks_of(m_disk))) m_count = blocks_of(m_disk) - 1;
               else m_count = int'(v);
               m_status = 0;
            end
         3: begin m_addr = v; m_status = 0; end
         4: m_cmd = v;
         default: ;
      endcase
   endtask

   task automatic bus_write(int idx, logic [DATA_W-1:0] v, int low, string tag);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1;
      req_addr  = ADDR_W'(idx * 8 + low); req_wdata = v;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      model_write(idx, v);
      check(rsp_valid == 1'b1, {tag, " R3 wr rsp_valid"}, rsp_valid, 1);
      check(rsp_rdata == '0, {tag, " R3 wr rdata"}, rsp_rdata, 0);
      check(rsp_err == (idx > 5), {tag, " R10 wr err"}, rsp_err, idx > 5);
      check(xfer_start == (idx == 4), {tag, " R8 start"}, xfer_start, idx == 4);
      check_outputs(tag);
   endtask

   task automatic bus_read(int idx, int low, string tag);
      logic [DATA_W-1:0] e;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_W'(idx * 8 + low);
      e = exp_read(idx);
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_valid == 1'b1, {tag, " R3 rd rsp_valid"}, rsp_valid, 1);
      check(rsp_rdata == e, {tag, " R9 rd data"}, rsp_rdata, e);
      check(rsp_err == (idx > 5), {tag, " R10 rd err"}, rsp_err, idx > 5);
   endtask

   initial begin
      #2_000_000;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
      check(xfer_start == 1'b0, "R1 start", xfer_start, 0);
      check_outputs("R1");
      bus_read(5, 0, "R1 status");

      // R2/R9/R10: every address read, low bits swept
      for (int a = 0; a < 64; a++) bus_read(a / 8, a % 8, "R2 sweep");
      @(negedge clk);
      check(rsp_valid == 1'b0, "R3 idle", rsp_valid, 0);

      // R4: disk numbers in and out of range
      for (int d = 0; d < 8; d++) begin
         bus_write(0, DATA_W'(d), 0, "R4 disk");
         bus_read(5, 0, "R4 status");
      end
      bus_write(0, 32'h0000_0102, 0, "R4 big");
      bus_read(5, 0, "R4 big status");

      // R5/R6/R9 per disk
      for (int d = 0; d < NDISK; d++) begin
         bus_write(0, DATA_W'(d), 0, "R4 select");
         bus_read(2, 0, "R9 size");
         for (int b = 0; b < 256; b++) bus_write(1, DATA_W'(b), 0, "R5 block");
         bus_write(1, 32'h0001_0000, 0, "R5 wide");
         bus_write(1, DATA_W'(blocks_of(d) - 1), 0, "R5 keep status");
         bus_read(5, 0, "R5 status");
         bus_read(1, 0, "R5 readback");
         for (int c = 0; c < 256; c++) bus_write(2, DATA_W'(c), 0, "R6 count");
         bus_write(2, 32'hFFFF_FFFF, 0, "R6 max");
         bus_read(5, 0, "R6 status");
      end

      // R7: address patterns, with low address bits set
      for (int i = 0; i < 32; i++) begin
         bus_write(1, 32'd300, 0, "R7 pre");
         bus_write(3, 32'h1 << i, i % 8, "R7 addr");
         bus_read(3, 0, "R7 readback");
         bus_read(5, 0, "R7 status");
      end

      // R8: command latch, strobe, status untouched
      bus_write(1, 32'd999, 0, "R8 pre");
      bus_write(4, 32'hA5A5_0001, 0, "R8 cmd");
      @(negedge clk);
      check(xfer_start == 1'b0, "R8 strobe ends", xfer_start, 0);
      bus_write(4, 32'h0000_0003, 0, "R8 cmd2");
      bus_read(5, 0, "R8 status");
      bus_read(4, 0, "R8 readback");

      // R10: unmapped writes and status write ignored
      bus_write(6, 32'h0, 0, "R10 idx6");
      bus_write(7, 32'h3, 0, "R10 idx7");
      bus_write(5, 32'h0, 0, "R10 status wr");
      for (int k = 0; k < 6; k++) bus_read(k, 0, "R10 after");

      @(negedge clk);
      check(rsp_valid == 1'b0, "R3 final idle", rsp_valid, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule